// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block is the digital controller that decides which multiplexer channel and which input configuration a multi-channel sampling converter uses for each conversion. A two-bit mode input selects one of four behaviours. Direct mode takes the channel and configuration from input pins. Scan mode steps through the channels with an internal counter. Program mode writes entries into a small sequence memory or reads them back. Run mode replays the stored sequence, one entry per conversion.

All strobes (write, read, conversion start) are active low and are sampled on the block clock, so their edges are seen one clock after they happen. A conversion request is taken only while the controller is idle and the busy input is low. The controller then issues a one-cycle launch pulse and tracks busy through one high period. When busy falls, it reports the channel that was actually converted.

The sequence memory is cleared only by reset. Its pointer returns to entry 0 whenever the mode changes. In run mode and in readback, the pointer wraps after the last entry written in the most recent program session.

Top module: `adc_seq_ctrl`

Conversion tracker states: `CV_IDLE` (waiting for a request), `CV_LAUNCH` (start pulse out), `CV_WAIT_HI` (waiting for busy to rise), `CV_WAIT_LO` (waiting for busy to fall). Transitions: `CV_IDLE`→`CV_LAUNCH` on an accepted start edge; `CV_LAUNCH`→`CV_WAIT_HI` unconditionally; `CV_WAIT_HI`→`CV_WAIT_LO` when busy is high; `CV_WAIT_LO`→`CV_IDLE` when busy is low, which is the completion of the conversion.

## Requirements
- R1: The mode input is decoded as follows: 2'b00 is direct, 2'b01 is scan, 2'b10 is program/readback, and 2'b11 is run.
- R2: In direct mode, while wr_n_i is low, mux_addr_o and mux_cfg_o follow addr_i and cfg_i combinationally. While wr_n_i is high, they hold the pin values captured at the last wr_n_i rising edge or conv_n_i falling edge.
- R3: In scan mode, mux_addr_o is the scan counter and mux_cfg_o is the configuration captured at a wr_n_i rise or conv_n_i fall. The counter is 0 after reset, advances after each completed scan-mode conversion, and wraps from SCAN_LAST to 0.
- R4: In program mode, a wr_n_i rising edge stores {addr_i, cfg_i} at the pointer. It then advances the pointer, wrapping at DEPTH-1. The highest location written in the session becomes the last entry.
- R5: In program mode, a rd_n_i falling edge places the entry at the pointer on rd_data_o and sets rd_oe_o. The entry is packed with the address in bits [6:3] and the configuration in bits [2:0]. A rd_n_i rising edge clears rd_oe_o and advances the pointer, wrapping to 0 after the last entry.
- R6: In run mode, each accepted conv_n_i falling edge converts the entry at the pointer and advances the pointer. The sequence starts at entry 0 and wraps to 0 after the last entry.
- R7: Any change of the mode input resets the pointer to entry 0.
- R8: When busy falls at the end of a conversion, res_valid_o pulses for one cycle. At the same time, res_addr_o presents the mux channel that was converted, not the pointer value.
- R9: A conv_n_i falling edge is ignored while busy_i is high, while a conversion is in progress, or in program mode.
- R10: The sequence memory contents survive mode switches. Returning to run mode replays the same entries.
- R11: After reset, mux_addr_o, mux_cfg_o, res_addr_o and rd_data_o are 0, and conv_start_o, res_valid_o and rd_oe_o are low.
- R12: An accepted start edge produces exactly one conv_start_o pulse, one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; clears all state including the sequence memory |
| mode_i | input | 2 | Operating mode select |
| wr_n_i | input | 1 | Active-low write / capture strobe |
| rd_n_i | input | 1 | Active-low readback strobe |
| conv_n_i | input | 1 | Active-low conversion start strobe (falling edge) |
| busy_i | input | 1 | Converter busy flag |
| addr_i | input | ADDR_W | Channel address pins |
| cfg_i | input | CFG_W | Input configuration pins |
| mux_addr_o | output | ADDR_W | Channel address driven to the multiplexer |
| mux_cfg_o | output | CFG_W | Configuration driven to the input stage |
| conv_start_o | output | 1 | One-cycle conversion launch pulse |
| res_addr_o | output | ADDR_W | Channel address belonging to the latest result |
| res_valid_o | output | 1 | One-cycle pulse when a result completes |
| rd_data_o | output | ADDR_W+CFG_W | Sequence entry read back |
| rd_oe_o | output | 1 | Readback data valid, high between rd_n_i fall and rise |

## Verification
Direct mode is driven in three ways: with the write strobe held low, with it released while the pins change, and with a start edge that carries fresh pin values. Together these separate pass-through from capture on a write rise and capture on a start fall. A full scan of all channels checks the counter ordering and its wrap at the boundary. A programmed three-entry sequence is replayed past its end in both readback and run, which exposes wrapping at the last written entry instead of at the memory depth. Start edges given during busy, in program mode, and around mode changes show whether the pointer advanced once, not at all, or was reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_SCAN   = 2'b01,
        MODE_PROG   = 2'b10,
        MODE_RUN    = 2'b11
    } seq_mode_e;

    typedef enum logic [1:0] {
        CV_IDLE    = 2'd0,
        CV_LAUNCH  = 2'd1,
        CV_WAIT_HI = 2'd2,
        CV_WAIT_LO = 2'd3
    } conv_st_e;

endpackage

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;

        // idle level of every active-low strobe is high
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= raw_n_i[g];
        end

        assign rise_o[g] = !prev_q && raw_n_i[g];
        assign fall_o[g] = prev_q && !raw_n_i[g];
    end

endmodule

// File: rtl/adc_seq_mem.sv
module adc_seq_mem #(
    parameter int unsigned ENT_W = 7,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PTR_W-1:0] idx_i,
    input  logic [ENT_W-1:0] wdata_i,
    output logic [ENT_W-1:0] rdata_o
);

    logic [ENT_W-1:0] ent_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [ENT_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= '0;
            else if (we_i && idx_i == PTR_W'(g))   q <= wdata_i;
        end

        assign ent_w[g] = q;
    end

    assign rdata_o = ent_w[idx_i];

endmodule

// File: rtl/adc_seq_conv_fsm.sv
module adc_seq_conv_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic busy_i,
    output logic accept_o,
    output logic launch_o,
    output logic done_o
);

    conv_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CV_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CV_IDLE:    if (start_req_i && !busy_i) st_d = CV_LAUNCH;
            CV_LAUNCH:  st_d = CV_WAIT_HI;
            CV_WAIT_HI: if (busy_i) st_d = CV_WAIT_LO;
            CV_WAIT_LO: if (!busy_i) st_d = CV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        launch_o = 1'b0;
        done_o   = 1'b0;
        unique case (st_q)
            CV_IDLE:    accept_o = start_req_i && !busy_i;
            CV_LAUNCH:  launch_o = 1'b1;
            CV_WAIT_HI: ;
            CV_WAIT_LO: done_o = !busy_i;
        endcase
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CFG_W     = 3,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned SCAN_LAST = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic                    wr_n_i,
    input  logic                    rd_n_i,
    input  logic                    conv_n_i,
    input  logic                    busy_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [CFG_W-1:0]        cfg_i,
    output logic [ADDR_W-1:0]       mux_addr_o,
    output logic [CFG_W-1:0]        mux_cfg_o,
    output logic                    conv_start_o,
    output logic [ADDR_W-1:0]       res_addr_o,
    output logic                    res_valid_o,
    output logic [ADDR_W+CFG_W-1:0] rd_data_o,
    output logic                    rd_oe_o
);

    localparam int unsigned ENT_W = ADDR_W + CFG_W;
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0]  PTR_TOP  = PTR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] SCAN_TOP = ADDR_W'(SCAN_LAST);

    // mode tracking
    seq_mode_e mode_cur, mode_q;
    logic      mode_chg;

    assign mode_cur = seq_mode_e'(mode_i);
    assign mode_chg = (mode_cur != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DIRECT;
        else        mode_q <= mode_cur;
    end

    // strobe edges: bit0 write, bit1 read, bit2 start
    logic [2:0] rise, fall;

    adc_seq_strobe #(.N(3)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_n_i ({conv_n_i, rd_n_i, wr_n_i}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    logic unused_edges;
    assign unused_edges = fall[0] ^ rise[2];

    // strobe actions are suppressed in the cycle a mode change is seen
    logic wr_up, rd_dn, rd_up, cv_dn;
    assign wr_up = rise[0] && !mode_chg;
    assign rd_dn = fall[1] && !mode_chg;
    assign rd_up = rise[1] && !mode_chg;
    assign cv_dn = fall[2] && !mode_chg;

    logic in_direct, in_scan, in_prog, in_run;
    assign in_direct = (mode_cur == MODE_DIRECT);
    assign in_scan   = (mode_cur == MODE_SCAN);
    assign in_prog   = (mode_cur == MODE_PROG);
    assign in_run    = (mode_cur == MODE_RUN);

    // conversion tracker
    logic accept, launch, done;

    adc_seq_conv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (cv_dn && !in_prog),
        .busy_i      (busy_i),
        .accept_o    (accept),
        .launch_o    (launch),
        .done_o      (done)
    );

    // sequence pointer and last-entry bookkeeping
    logic [PTR_W-1:0] ptr_q, ptr_d, last_q, ptr_wrap_last, ptr_wrap_top;
    logic             fresh_q;
    logic             mem_we;
    logic [ENT_W-1:0] mem_rd;

    assign ptr_wrap_last = (ptr_q >= last_q)  ? '0 : ptr_q + 1'b1;
    assign ptr_wrap_top  = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;
    assign mem_we        = in_prog && wr_up;

    always_comb begin
        ptr_d = ptr_q;
        if (mode_chg)                 ptr_d = '0;
        else if (in_prog && wr_up)    ptr_d = ptr_wrap_top;
        else if (in_prog && rd_up)    ptr_d = ptr_wrap_last;
        else if (in_run && accept)    ptr_d = ptr_wrap_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            last_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            if (mode_chg) begin
                fresh_q <= in_prog;
            end else if (mem_we) begin
                fresh_q <= 1'b0;
                if (fresh_q || ptr_q > last_q) last_q <= ptr_q;
            end
        end
    end

    adc_seq_mem #(.ENT_W(ENT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .idx_i   (ptr_q),
        .wdata_i ({addr_i, cfg_i}),
        .rdata_o (mem_rd)
    );

    // held pin values (direct and scan) and scan counter
    logic [ADDR_W-1:0] hold_addr_q, scan_q;
    logic [CFG_W-1:0]  hold_cfg_q;
    logic              capture;

    assign capture = (in_direct || in_scan) && (wr_up || cv_dn);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr_q <= '0;
            hold_cfg_q  <= '0;
        end else if (capture) begin
            hold_cfg_q <= cfg_i;
            if (in_direct) hold_addr_q <= addr_i;
        end
    end

    // conversion bookkeeping
    logic [ADDR_W-1:0] conv_addr_q, conv_sel, res_addr_q;
    logic              conv_scan_q, res_valid_q;

    always_comb begin
        unique case (mode_cur)
            MODE_DIRECT: conv_sel = addr_i;
            MODE_SCAN:   conv_sel = scan_q;
            MODE_PROG,
            MODE_RUN:    conv_sel = mem_rd[ENT_W-1:CFG_W];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_addr_q <= '0;
            conv_scan_q <= 1'b0;
            scan_q      <= '0;
            res_addr_q  <= '0;
            res_valid_q <= 1'b0;
        end else begin
            res_valid_q <= done;
            if (accept) begin
                conv_addr_q <= conv_sel;
                conv_scan_q <= in_scan;
            end
            if (done) begin
                res_addr_q <= conv_addr_q;
                if (conv_scan_q) scan_q <= (scan_q == SCAN_TOP) ? '0 : scan_q + 1'b1;
            end
        end
    end

    // readback path
    logic [ENT_W-1:0] rd_data_q;
    logic             rd_oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            rd_oe_q   <= 1'b0;
        end else if (mode_chg) begin
            rd_oe_q <= 1'b0;
        end else if (in_prog && rd_dn) begin
            rd_data_q <= mem_rd;
            rd_oe_q   <= 1'b1;
        end else if (in_prog && rd_up) begin
            rd_oe_q <= 1'b0;
        end
    end

    // multiplexer drive
    always_comb begin
        unique case (mode_cur)
            MODE_DIRECT: begin
                mux_addr_o = wr_n_i ? hold_addr_q : addr_i;
                mux_cfg_o  = wr_n_i ? hold_cfg_q  : cfg_i;
            end
            MODE_SCAN: begin
                mux_addr_o = scan_q;
                mux_cfg_o  = hold_cfg_q;
            end
            MODE_PROG,
            MODE_RUN: begin
                mux_addr_o = mem_rd[ENT_W-1:CFG_W];
                mux_cfg_o  = mem_rd[CFG_W-1:0];
            end
        endcase
    end

    assign conv_start_o = launch;
    assign res_addr_o   = res_addr_q;
    assign res_valid_o  = res_valid_q;
    assign rd_data_o    = rd_data_q;
    assign rd_oe_o      = rd_oe_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              wr_n_i,
    input logic              conv_n_i,
    input logic              busy_i,
    input logic [ADDR_W-1:0] mux_addr_o,
    input logic              conv_start_o,
    input logic              res_valid_o,
    input logic [PTR_W-1:0]  ptr_q
);

    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(conv_n_i) && busy_i) |=> !conv_start_o);

    assert_prog_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(conv_n_i) && mode_i == MODE_PROG) |=> !conv_start_o);

    assert_mode_ptr_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |=> (ptr_q == '0));

    assert_direct_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIRECT && wr_n_i && $past(wr_n_i) && conv_n_i)
        |=> (mode_i != MODE_DIRECT || !wr_n_i || $stable(mux_addr_o)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .wr_n_i       (wr_n_i),
    .conv_n_i     (conv_n_i),
    .busy_i       (busy_i),
    .mux_addr_o   (mux_addr_o),
    .conv_start_o (conv_start_o),
    .res_valid_o  (res_valid_o),
    .ptr_q        (ptr_q)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       wr_n_i = 1'b1, rd_n_i = 1'b1, conv_n_i = 1'b1, busy_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [2:0] cfg_i = '0;
    logic [3:0] mux_addr_o, res_addr_o;
    logic [2:0] mux_cfg_o;
    logic       conv_start_o, res_valid_o, rd_oe_o;
    logic [6:0] rd_data_o;

    int n_chk = 0, n_bad = 0;
    int n_starts = 0, n_res = 0, busy_cnt = 0;
    logic [3:0] last_res = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_n_i(wr_n_i), .rd_n_i(rd_n_i),
        .conv_n_i(conv_n_i), .busy_i(busy_i), .addr_i(addr_i), .cfg_i(cfg_i),
        .mux_addr_o(mux_addr_o), .mux_cfg_o(mux_cfg_o), .conv_start_o(conv_start_o),
        .res_addr_o(res_addr_o), .res_valid_o(res_valid_o), .rd_data_o(rd_data_o),
        .rd_oe_o(rd_oe_o)
    );

    // converter model: busy for BUSY_CYC cycles after each launch
    always @(negedge clk) begin
        if (conv_start_o) begin
            n_starts++;
            busy_cnt = BUSY_CYC;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        busy_i = (busy_cnt != 0);
        if (res_valid_o) begin
            n_res++;
            last_res = res_addr_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_i = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic convert(input logic [3:0] exp, input string req);
        int base = n_res;
        @(negedge clk); conv_n_i = 1'b0;
        @(negedge clk); conv_n_i = 1'b1;
        for (int k = 0; k < 40 && n_res == base; k++) @(posedge clk);
        @(negedge clk);
        chk(n_res == base + 1, {req, " result count"}, n_res - base, 1);
        chk(last_res == exp, {req, " converted channel"}, last_res, exp);
    endtask

    task automatic write_entry(input logic [3:0] a, input logic [2:0] c);
        @(negedge clk); addr_i = a; cfg_i = c; wr_n_i = 1'b0;
        @(negedge clk); wr_n_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(mux_addr_o == 0 && mux_cfg_o == 0, "R11 mux after reset", mux_addr_o, 0);
        chk(!conv_start_o && !res_valid_o && !rd_oe_o, "R11 strobes after reset",
            {conv_start_o, res_valid_o, rd_oe_o}, 0);
        chk(res_addr_o == 0 && rd_data_o == 0, "R11 data after reset", rd_data_o, 0);
    endtask

    task automatic t_direct;
        int s0;
        set_mode(2'b00);                         // R1 direct code
        @(negedge clk); addr_i = 4'd5; cfg_i = 3'd3; wr_n_i = 1'b0;
        #1 chk(mux_addr_o == 5 && mux_cfg_o == 3, "R2 passthrough", mux_addr_o, 5);
        @(negedge clk); wr_n_i = 1'b1;
        @(negedge clk); addr_i = 4'd9; cfg_i = 3'd1;
        @(negedge clk);
        chk(mux_addr_o == 5, "R2 held address", mux_addr_o, 5);
        chk(mux_cfg_o == 3, "R2 held config", mux_cfg_o, 3);
        addr_i = 4'd12; cfg_i = 3'd6;
        s0 = n_starts;
        convert(4'd12, "R8 direct");
        chk(mux_addr_o == 12 && mux_cfg_o == 6, "R2 capture on start", mux_addr_o, 12);
        chk(n_starts - s0 == 1, "R12 one launch pulse", n_starts - s0, 1);
    endtask

    task automatic t_scan;
        set_mode(2'b01);                         // R1 scan code
        chk(mux_addr_o == 0, "R3 scan starts at 0", mux_addr_o, 0);
        @(negedge clk); cfg_i = 3'd4; wr_n_i = 1'b0;
        @(negedge clk); wr_n_i = 1'b1;
        @(negedge clk);
        chk(mux_cfg_o == 4, "R3 scan config capture", mux_cfg_o, 4);
        for (int i = 0; i < 16; i++) convert(4'(i), "R3 scan order");
        chk(mux_addr_o == 0, "R3 scan wrap", mux_addr_o, 0);
    endtask

    task automatic t_program;
        set_mode(2'b10);                         // R1 program code
        write_entry(4'd7, 3'd2);
        write_entry(4'd3, 3'd5);
        write_entry(4'd11, 3'd1);
        chk(mux_addr_o == 0, "R4 pointer advanced to unwritten entry", mux_addr_o, 0);
    endtask

    task automatic t_readback;
        logic [6:0] exp [4];
        exp[0] = 7'h3A; exp[1] = 7'h1D; exp[2] = 7'h59; exp[3] = 7'h3A;
        set_mode(2'b00);
        set_mode(2'b10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rd_n_i = 1'b0;
            @(negedge clk);
            chk(rd_oe_o == 1'b1, "R5 output enable", rd_oe_o, 1);
            chk(rd_data_o == exp[i], "R5 R4 readback entry", rd_data_o, exp[i]);
            rd_n_i = 1'b1;
            @(negedge clk);
            chk(rd_oe_o == 1'b0, "R5 output released", rd_oe_o, 0);
        end
    endtask

    task automatic t_run;
        set_mode(2'b11);                         // R1 run code
        chk(mux_addr_o == 7 && mux_cfg_o == 2, "R6 run starts at entry 0", mux_addr_o, 7);
        convert(4'd7, "R6 entry0");
        convert(4'd3, "R6 entry1");
        convert(4'd11, "R6 entry2");
        convert(4'd7, "R6 wrap");
        convert(4'd3, "R6 after wrap");
    endtask

    task automatic t_busy_ignore;
        int s0 = n_starts;
        int r0 = n_res;
        @(negedge clk); conv_n_i = 1'b0;
        @(negedge clk); conv_n_i = 1'b1;
        @(negedge clk); conv_n_i = 1'b0;         // busy is high here
        @(negedge clk); conv_n_i = 1'b1;
        for (int k = 0; k < 40 && n_res == r0; k++) @(posedge clk);
        repeat (4) @(negedge clk);
        chk(n_starts - s0 == 1, "R9 start during busy ignored", n_starts - s0, 1);
        chk(last_res == 11, "R9 R8 first result", last_res, 11);
        convert(4'd7, "R9 pointer advanced once");
        set_mode(2'b10);
        s0 = n_starts;
        @(negedge clk); conv_n_i = 1'b0;
        @(negedge clk); conv_n_i = 1'b1;
        repeat (10) @(negedge clk);
        chk(n_starts == s0, "R9 start in program mode ignored", n_starts - s0, 0);
    endtask

    task automatic t_mode_reset;
        set_mode(2'b11);
        convert(4'd7, "R7 reset on entry");
        convert(4'd3, "R7 second");
        set_mode(2'b01);
        set_mode(2'b11);
        convert(4'd7, "R7 R10 after switch");
        convert(4'd3, "R10 memory kept");
        convert(4'd11, "R10 memory kept last");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_direct;
        t_scan;
        t_program;
        t_readback;
        t_run;
        t_busy_ignore;
        t_mode_reset;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule